// File: doc/BRIEF.md
# Serial Audio Frame Serializer

This block is the serial audio port of a sound-processing core. From the core clock it generates a bit clock and a word-select line. It shifts parallel stereo samples out on several serial data lanes, and it assembles one serial input lane back into a parallel stereo pair. A frame has two channel halves of 32 bit slots each. One frame is one sample period of the core.

Each output lane takes a left and a right sample in parallel. The sample width can be set to 16, 18 or 20 bits. The input lane always carries 16-bit samples. Word select follows one of two alignments, picked by a configuration input. In the I2S alignment the first data bit comes one slot after the word-select edge. In the LSB-justified alignment each sample ends in the last slot of its half. The configuration and the output samples are taken once per frame, so software can update them at any time during a frame without corrupting the frame in flight.

Top module: `afs_serial_port`

## Requirements
- R1: While reset is asserted, the bit clock, word select, every data lane, the frame strobe, the capture-valid pulse and both captured words are all 0.
- R2: The bit clock repeats every 16 core clocks, low for 8 and then high for 8. A frame is 64 bit periods, which is 1024 core clocks. The frame strobe is high for exactly one core clock at the start of slot 0, while the bit clock is low.
- R3: Word select and every data lane change only in the core clock in which the bit clock falls. Each value is therefore stable for 8 core clocks before the bit clock rises and for 8 core clocks after it.
- R4: With fmt_rj_i = 0 (I2S), word select is 0 in slots 63 and 0..30 and is 1 in slots 31..62. The left sample starts at slot 0 and the right sample starts at slot 32, both MSB first.
- R5: With fmt_rj_i = 1 (LSB-justified), word select is 1 in slots 0..31 (left) and 0 in slots 32..63 (right). The LSB of each sample sits in slot 31 (left) or slot 63 (right), with the MSB first.
- R6: width_sel_i gives the output width: 0 selects 16 bits, 1 selects 18 bits, and 2 or 3 select 20 bits. A lane sends bits [W-1:0] of its sample word and ignores the bits above them. Every slot that carries no sample bit is driven 0.
- R7: Each output lane sends its own sample pair, independently of the other lanes, under the shared bit clock and word select.
- R8: The samples and the configuration are sampled once per frame, at the core clock edge one cycle before the frame strobe rises. Changes made at other times do not alter the frame already in progress.
- R9: sdin_i is sampled at each rising edge of the bit clock as 16-bit samples, with the same alignment as the outputs. Slots outside those 16 bits are ignored. The completed pair appears on rx_left_o and rx_right_o together with a one-cycle rx_valid_o pulse, in the same cycle as the next frame strobe, and stays there until the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fmt_rj_i | input | 1 | Alignment select: 0 = I2S, 1 = LSB-justified |
| width_sel_i | input | 2 | Output width: 0 = 16, 1 = 18, 2 or 3 = 20 bits |
| tx_left_i | input | NUM_TX*SAMPLE_W | Left samples, lane n in bits [n*SAMPLE_W +: SAMPLE_W] |
| tx_right_i | input | NUM_TX*SAMPLE_W | Right samples, same packing |
| sdin_i | input | 1 | Serial audio input lane |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sdout_o | output | NUM_TX | Serial output lanes, one bit per lane |
| frame_o | output | 1 | One-cycle strobe at the start of each frame |
| rx_left_o | output | RX_W | Last captured left input sample |
| rx_right_o | output | RX_W | Last captured right input sample |
| rx_valid_o | output | 1 | One-cycle pulse when a new input pair is presented |

## Verification
Every output is registered from a single frame counter. The bench therefore locks onto the frame strobe and counts core clocks from there. The bit clock is due high 8 clocks into each slot. The bench reads each slot's data and word select at that point, and it compares the value seen in the slot's first clock with the values in all 16 clocks. Samples and configuration are applied in the strobe cycle and checked in the frame that starts at the following strobe, one frame later. The input bits driven during a frame are checked at the strobe after that frame, 1024 clocks on, together with the valid pulse. A change applied in the middle of a frame is checked twice: the running frame must not change, and the change must take effect in the next frame.

// File: rtl/afs_pkg.sv
package afs_pkg;

  typedef enum logic {
    FMT_I2S = 1'b0,
    FMT_RJ  = 1'b1
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic [1:0] wsel;
  } cfg_t;

  // Output sample width for a width-select code.
  function automatic int width_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 18;
      default: return 20;
    endcase
  endfunction

endpackage

// File: rtl/afs_frame_timer.sv
module afs_frame_timer
  import afs_pkg::*;
#(
  parameter int unsigned BIT_DIV      = 16,
  parameter int unsigned SLOTS_PER_CH = 32,
  localparam int unsigned SL_W        = $clog2(2 * SLOTS_PER_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  cfg_t            cfg_i,
  output logic            bclk_o,
  output logic            ws_o,
  output logic            frame_o,
  output logic [SL_W-1:0] slot_o,
  output logic            sample_en_o,
  output logic            frame_start_o,
  output logic            frame_end_o,
  output cfg_t            cfg_o
);

  localparam int unsigned PH_W     = $clog2(BIT_DIV);
  localparam int unsigned SLOT_CNT = 2 * SLOTS_PER_CH;
  localparam int unsigned HALF     = BIT_DIV / 2;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [SL_W-1:0] slot_q, slot_d;
  cfg_t            cfg_q, cfg_d;
  logic            bclk_q, bclk_d;
  logic            ws_q, ws_d;
  logic            frame_q, frame_d;
  logic            phase_last, slot_last, frame_end, frame_start;

  always_comb begin
    phase_last  = (phase_q == PH_W'(BIT_DIV - 1));
    slot_last   = (slot_q == SL_W'(SLOT_CNT - 1));
    frame_end   = phase_last && slot_last;
    frame_start = (phase_q == '0) && (slot_q == '0);

    phase_d = phase_last ? '0 : phase_q + 1'b1;
    slot_d  = slot_q;
    if (phase_last) begin
      slot_d = slot_last ? '0 : slot_q + 1'b1;
    end

    cfg_d = frame_end ? cfg_i : cfg_q;

    bclk_d = (phase_q >= PH_W'(HALF));
    if (cfg_q.fmt == FMT_I2S) begin
      ws_d = (slot_q >= SL_W'(SLOTS_PER_CH - 1)) && !slot_last;
    end else begin
      ws_d = (slot_q < SL_W'(SLOTS_PER_CH));
    end
    frame_d = frame_start;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      slot_q  <= '0;
      cfg_q   <= '{fmt: FMT_I2S, wsel: 2'd0};
      bclk_q  <= 1'b0;
      ws_q    <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      slot_q  <= slot_d;
      cfg_q   <= cfg_d;
      bclk_q  <= bclk_d;
      ws_q    <= ws_d;
      frame_q <= frame_d;
    end
  end

  assign bclk_o        = bclk_q;
  assign ws_o          = ws_q;
  assign frame_o       = frame_q;
  assign slot_o        = slot_q;
  assign sample_en_o   = (phase_q == PH_W'(HALF));
  assign frame_start_o = frame_start;
  assign frame_end_o   = frame_end;
  assign cfg_o         = cfg_q;

  // Checker state: core clocks elapsed since the last bit-clock rise.
  logic            bclk_prev_q, rise_seen_q, rise_now;
  logic [PH_W+1:0] gap_q;

  assign rise_now = bclk_q && !bclk_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_prev_q <= 1'b0;
      rise_seen_q <= 1'b0;
      gap_q       <= '0;
    end else begin
      bclk_prev_q <= bclk_q;
      if (rise_now) begin
        rise_seen_q <= 1'b1;
        gap_q       <= (PH_W + 2)'(1);
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  p_bclk_period_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_now && rise_seen_q) |-> (gap_q == (PH_W + 2)'(BIT_DIV)));

  p_frame_low_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |-> !bclk_q);

  p_frame_pulse_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_q |=> !frame_q);

  p_ws_on_fall_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_q != $past(ws_q)) |-> $fell(bclk_q));

  p_i2s_left_low_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && cfg_q.fmt == FMT_I2S) |=> !ws_q);

  p_rj_left_high_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && cfg_q.fmt == FMT_RJ) |=> ws_q);

  p_cfg_hold_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_end |=> $stable(cfg_q));

endmodule

// File: rtl/afs_tx_lane.sv
module afs_tx_lane
  import afs_pkg::*;
#(
  parameter int unsigned SAMPLE_W     = 20,
  parameter int unsigned SLOTS_PER_CH = 32,
  localparam int unsigned SL_W        = $clog2(2 * SLOTS_PER_CH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                frame_end_i,
  input  cfg_t                cfg_i,
  input  logic [SL_W-1:0]     slot_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                sd_o
);

  localparam int unsigned IDX_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] hold_l_q, hold_l_d;
  logic [SAMPLE_W-1:0] hold_r_q, hold_r_d;
  logic [SAMPLE_W-1:0] word;
  logic                sd_q, sd_d;

  always_comb begin
    int pos;
    int w;
    int idx;
    hold_l_d = frame_end_i ? left_i  : hold_l_q;
    hold_r_d = frame_end_i ? right_i : hold_r_q;

    if (slot_i >= SL_W'(SLOTS_PER_CH)) begin
      pos  = int'(slot_i) - int'(SLOTS_PER_CH);
      word = hold_r_q;
    end else begin
      pos  = int'(slot_i);
      word = hold_l_q;
    end

    w = width_bits(cfg_i.wsel);
    if (w > int'(SAMPLE_W)) w = int'(SAMPLE_W);

    // Bit index carried by this slot; outside [0, w) the slot is empty.
    if (cfg_i.fmt == FMT_I2S) idx = w - 1 - pos;
    else                      idx = int'(SLOTS_PER_CH) - 1 - pos;

    sd_d = 1'b0;
    if (idx >= 0 && idx < w) sd_d = word[IDX_W'(idx)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l_q <= '0;
      hold_r_q <= '0;
      sd_q     <= 1'b0;
    end else begin
      hold_l_q <= hold_l_d;
      hold_r_q <= hold_r_d;
      sd_q     <= sd_d;
    end
  end

  assign sd_o = sd_q;

  // The last slot of the left half never carries a bit in I2S alignment.
  p_i2s_tail_zero_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((SLOTS_PER_CH > SAMPLE_W) && cfg_i.fmt == FMT_I2S &&
     slot_i == SL_W'(SLOTS_PER_CH - 1)) |=> !sd_q);

  // The first slot of the left half never carries a bit in LSB-justified alignment.
  p_rj_head_zero_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((SLOTS_PER_CH > SAMPLE_W) && cfg_i.fmt == FMT_RJ && slot_i == '0) |=> !sd_q);

endmodule

// File: rtl/afs_rx_lane.sv
module afs_rx_lane
  import afs_pkg::*;
#(
  parameter int unsigned RX_W         = 16,
  parameter int unsigned SLOTS_PER_CH = 32,
  localparam int unsigned SL_W        = $clog2(2 * SLOTS_PER_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  fmt_e            fmt_i,
  input  logic [SL_W-1:0] slot_i,
  input  logic            sample_en_i,
  input  logic            frame_start_i,
  input  logic            sd_i,
  output logic [RX_W-1:0] left_o,
  output logic [RX_W-1:0] right_o,
  output logic            valid_o
);

  localparam int unsigned IDX_W = $clog2(RX_W);

  logic [RX_W-1:0] acc_l_q, acc_l_d;
  logic [RX_W-1:0] acc_r_q, acc_r_d;
  logic [RX_W-1:0] cap_l_q, cap_l_d;
  logic [RX_W-1:0] cap_r_q, cap_r_d;
  logic            valid_q, valid_d;

  always_comb begin
    int  pos;
    int  idx;
    logic right;
    acc_l_d = acc_l_q;
    acc_r_d = acc_r_q;

    right = (slot_i >= SL_W'(SLOTS_PER_CH));
    pos   = right ? int'(slot_i) - int'(SLOTS_PER_CH) : int'(slot_i);
    if (fmt_i == FMT_I2S) idx = int'(RX_W) - 1 - pos;
    else                  idx = int'(SLOTS_PER_CH) - 1 - pos;

    if (sample_en_i && idx >= 0 && idx < int'(RX_W)) begin
      if (right) acc_r_d[IDX_W'(idx)] = sd_i;
      else       acc_l_d[IDX_W'(idx)] = sd_i;
    end

    cap_l_d = frame_start_i ? acc_l_q : cap_l_q;
    cap_r_d = frame_start_i ? acc_r_q : cap_r_q;
    valid_d = frame_start_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_l_q <= '0;
      acc_r_q <= '0;
      cap_l_q <= '0;
      cap_r_q <= '0;
      valid_q <= 1'b0;
    end else begin
      acc_l_q <= acc_l_d;
      acc_r_q <= acc_r_d;
      cap_l_q <= cap_l_d;
      cap_r_q <= cap_r_d;
      valid_q <= valid_d;
    end
  end

  assign left_o  = cap_l_q;
  assign right_o = cap_r_q;
  assign valid_o = valid_q;

  p_rx_pulse_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  p_rx_hold_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> (cap_l_q == $past(cap_l_q) && cap_r_q == $past(cap_r_q)));

endmodule

// File: rtl/afs_serial_port.sv
module afs_serial_port
  import afs_pkg::*;
#(
  parameter int unsigned NUM_TX       = 2,
  parameter int unsigned SAMPLE_W     = 20,
  parameter int unsigned RX_W         = 16,
  parameter int unsigned BIT_DIV      = 16,
  parameter int unsigned SLOTS_PER_CH = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         fmt_rj_i,
  input  logic [1:0]                   width_sel_i,
  input  logic [NUM_TX*SAMPLE_W-1:0]   tx_left_i,
  input  logic [NUM_TX*SAMPLE_W-1:0]   tx_right_i,
  input  logic                         sdin_i,
  output logic                         bclk_o,
  output logic                         ws_o,
  output logic [NUM_TX-1:0]            sdout_o,
  output logic                         frame_o,
  output logic [RX_W-1:0]              rx_left_o,
  output logic [RX_W-1:0]              rx_right_o,
  output logic                         rx_valid_o
);

  localparam int unsigned SL_W = $clog2(2 * SLOTS_PER_CH);

  logic [1:0]      rst_sync_q;
  logic            rst_n;
  cfg_t            cfg_in, cfg_cur;
  logic [SL_W-1:0] slot;
  logic            sample_en, frame_start, frame_end;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign cfg_in = '{fmt: fmt_e'(fmt_rj_i), wsel: width_sel_i};

  afs_frame_timer #(
    .BIT_DIV      (BIT_DIV),
    .SLOTS_PER_CH (SLOTS_PER_CH)
  ) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .cfg_i         (cfg_in),
    .bclk_o        (bclk_o),
    .ws_o          (ws_o),
    .frame_o       (frame_o),
    .slot_o        (slot),
    .sample_en_o   (sample_en),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end),
    .cfg_o         (cfg_cur)
  );

  for (genvar g = 0; g < NUM_TX; g++) begin : g_tx
    afs_tx_lane #(
      .SAMPLE_W     (SAMPLE_W),
      .SLOTS_PER_CH (SLOTS_PER_CH)
    ) u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_n),
      .frame_end_i (frame_end),
      .cfg_i       (cfg_cur),
      .slot_i      (slot),
      .left_i      (tx_left_i[g*SAMPLE_W +: SAMPLE_W]),
      .right_i     (tx_right_i[g*SAMPLE_W +: SAMPLE_W]),
      .sd_o        (sdout_o[g])
    );

    p_sd_on_fall_r3 : assert property (@(posedge clk_i) disable iff (!rst_n)
      (sdout_o[g] != $past(sdout_o[g])) |-> $fell(bclk_o));
  end

  afs_rx_lane #(
    .RX_W         (RX_W),
    .SLOTS_PER_CH (SLOTS_PER_CH)
  ) u_rx (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .fmt_i         (cfg_cur.fmt),
    .slot_i        (slot),
    .sample_en_i   (sample_en),
    .frame_start_i (frame_start),
    .sd_i          (sdin_i),
    .left_o        (rx_left_o),
    .right_o       (rx_right_o),
    .valid_o       (rx_valid_o)
  );

  p_valid_frame_r9 : assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_valid_o == frame_o);

endmodule

// File: tb/afs_serial_port_bench.sv
module afs_serial_port_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fmt_rj;
  logic [1:0]  wsel;
  logic [19:0] l0, r0, l1, r1;
  logic        sdin;
  logic        bclk, ws, frame, rx_valid;
  logic [1:0]  sdout;
  logic [15:0] rx_l, rx_r;

  int n_chk = 0;
  int n_err = 0;

  logic [63:0] cap0, cap1, capws;
  logic        stab_ok, shape_ok;

  logic        mid_en;
  logic        mid_rj;
  logic [1:0]  mid_wsel;
  logic [19:0] mid_l0, mid_r0, mid_l1, mid_r1;

  always #10 clk = ~clk;

  afs_serial_port u_afs_serial_port (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fmt_rj_i    (fmt_rj),
    .width_sel_i (wsel),
    .tx_left_i   ({l1, l0}),
    .tx_right_i  ({r1, r0}),
    .sdin_i      (sdin),
    .bclk_o      (bclk),
    .ws_o        (ws),
    .sdout_o     (sdout),
    .frame_o     (frame),
    .rx_left_o   (rx_l),
    .rx_right_o  (rx_r),
    .rx_valid_o  (rx_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input logic [1:0] s);
    if (s == 2'd0) return 16;
    if (s == 2'd1) return 18;
    return 20;
  endfunction

  // Expected serial line, bit s = slot s.
  function automatic logic [63:0] exp_tx(input logic [19:0] l, input logic [19:0] r,
                                         input logic [1:0] s_w, input logic rjm);
    logic [63:0] v = '0;
    int w = wbits(s_w);
    for (int s = 0; s < 64; s++) begin
      logic [19:0] smp = (s < 32) ? l : r;
      int p = s % 32;
      if (!rjm) begin
        if (p < w) v[s] = smp[w-1-p];
      end else begin
        if (p >= 32 - w) v[s] = smp[31-p];
      end
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_ws(input logic rjm);
    logic [63:0] v = '0;
    for (int s = 0; s < 64; s++) begin
      if (rjm) v[s] = (s < 32);
      else     v[s] = (s >= 31) && (s != 63);
    end
    return v;
  endfunction

  // Input line; slots outside the 16 data bits carry 1s that must be ignored.
  function automatic logic [63:0] rx_line(input logic [15:0] l, input logic [15:0] r,
                                          input logic rjm);
    logic [63:0] v = '1;
    for (int s = 0; s < 64; s++) begin
      logic [15:0] smp = (s < 32) ? l : r;
      int p = s % 32;
      if (!rjm && p < 16)  v[s] = smp[15-p];
      if (rjm && p >= 16)  v[s] = smp[31-p];
    end
    return v;
  endfunction

  task automatic wait_frame();
    @(negedge clk);
    while (!frame) @(negedge clk);
  endtask

  task automatic apply(input logic rjm, input logic [1:0] s_w, input logic [19:0] a0,
                       input logic [19:0] b0, input logic [19:0] a1, input logic [19:0] b1);
    fmt_rj = rjm; wsel = s_w; l0 = a0; r0 = b0; l1 = a1; r1 = b1;
  endtask

  // Entered at the negedge of a frame-strobe cycle; leaves at the next one.
  task automatic capture_frame(input logic [63:0] rxb);
    logic f0, f1, fw;
    stab_ok = 1'b1; shape_ok = 1'b1;
    f0 = 1'b0; f1 = 1'b0; fw = 1'b0;
    for (int s = 0; s < 64; s++) begin
      sdin = rxb[s];
      for (int k = 0; k < 16; k++) begin
        if (mid_en && s == 20 && k == 3) begin
          apply(mid_rj, mid_wsel, mid_l0, mid_r0, mid_l1, mid_r1);
          mid_en = 1'b0;
        end
        if (k == 0) begin
          f0 = sdout[0]; f1 = sdout[1]; fw = ws;
        end else if (sdout[0] !== f0 || sdout[1] !== f1 || ws !== fw) begin
          stab_ok = 1'b0;
        end
        if (bclk !== (k >= 8)) shape_ok = 1'b0;
        if (frame !== (s == 0 && k == 0)) shape_ok = 1'b0;
        if (k == 8) begin
          cap0[s] = sdout[0]; cap1[s] = sdout[1]; capws[s] = ws;
        end
        @(negedge clk);
      end
    end
  endtask

  task automatic verify(input string req, input logic rjm, input logic [1:0] s_w,
                        input logic [19:0] a0, input logic [19:0] b0,
                        input logic [19:0] a1, input logic [19:0] b1,
                        input logic [15:0] xl, input logic [15:0] xr);
    chk(req,  "lane0 slots", cap0, exp_tx(a0, b0, s_w, rjm));
    chk("R7", "lane1 slots", cap1, exp_tx(a1, b1, s_w, rjm));
    chk(req,  "word select", capws, exp_ws(rjm));
    chk("R3", "mid-slot stability", {63'd0, stab_ok}, 64'd1);
    chk("R2", "bit clock and strobe shape", {63'd0, shape_ok}, 64'd1);
    chk("R2", "strobe after 1024 clocks", {63'd0, frame}, 64'd1);
    chk("R9", "rx valid", {63'd0, rx_valid}, 64'd1);
    chk("R9", "rx left",  {48'd0, rx_l}, {48'd0, xl});
    chk("R9", "rx right", {48'd0, rx_r}, {48'd0, xr});
  endtask

  task automatic run_case(input string req, input logic rjm, input logic [1:0] s_w,
                          input logic [19:0] a0, input logic [19:0] b0,
                          input logic [19:0] a1, input logic [19:0] b1,
                          input logic [15:0] xl, input logic [15:0] xr);
    wait_frame();
    apply(rjm, s_w, a0, b0, a1, b1);
    wait_frame();
    capture_frame(rx_line(xl, xr, rjm));
    verify(req, rjm, s_w, a0, b0, a1, b1, xl, xr);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; fmt_rj = 1'b0; wsel = 2'd0; sdin = 1'b0; mid_en = 1'b0;
    l0 = '0; r0 = '0; l1 = '0; r1 = '0;
    repeat (5) @(negedge clk);
    chk("R1", "bclk in reset", {63'd0, bclk}, 64'd0);
    chk("R1", "ws in reset", {63'd0, ws}, 64'd0);
    chk("R1", "lanes in reset", {62'd0, sdout}, 64'd0);
    chk("R1", "strobes in reset", {62'd0, frame, rx_valid}, 64'd0);
    chk("R1", "captures in reset", {32'd0, rx_l, rx_r}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_i2s16();   // R4, R6 upper bits ignored
    run_case("R4", 1'b0, 2'd0, 20'hF_A5C3, 20'h0_1234, 20'h3_0F0F, 20'hC_8001,
             16'hC35A, 16'h8001);
  endtask

  task automatic t_i2s20();   // R6 full width in I2S
    run_case("R6", 1'b0, 2'd2, 20'h8_0001, 20'h7_FFFE, 20'hA_5A5A, 20'h1_3579,
             16'h00FF, 16'hFF00);
  endtask

  task automatic t_rj18();    // R5, R6: bits 19..18 ignored at 18-bit width
    run_case("R5", 1'b1, 2'd1, 20'hF_FFFF, 20'h2_5A5A, 20'h1_2345, 20'h0_0001,
             16'h1234, 16'hFEDC);
  endtask

  task automatic t_rj_code3(); // R6: code 3 behaves as 20 bits
    run_case("R6", 1'b1, 2'd3, 20'h9_0F1E, 20'hE_7C3B, 20'h0_0003, 20'hF_0000,
             16'hA5A5, 16'h5A5A);
  endtask

  task automatic t_mid_change(); // R8
    wait_frame();
    apply(1'b0, 2'd0, 20'h0_BEEF, 20'h0_CAFE, 20'h0_1111, 20'h0_2222);
    mid_rj = 1'b1; mid_wsel = 2'd2;
    mid_l0 = 20'h8_4211; mid_r0 = 20'h3_C3C3; mid_l1 = 20'hF_0F0F; mid_r1 = 20'h0_8888;
    wait_frame();
    mid_en = 1'b1;
    capture_frame(rx_line(16'h0F0F, 16'hF0F0, 1'b0));
    verify("R8", 1'b0, 2'd0, 20'h0_BEEF, 20'h0_CAFE, 20'h0_1111, 20'h0_2222,
           16'h0F0F, 16'hF0F0);
    capture_frame(rx_line(16'h7E81, 16'h0180, 1'b1));
    verify("R8", 1'b1, 2'd2, 20'h8_4211, 20'h3_C3C3, 20'hF_0F0F, 20'h0_8888,
           16'h7E81, 16'h0180);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_i2s16();
    t_i2s20();
    t_rj18();
    t_rj_code3();
    t_mid_change();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule